// File: doc/BRIEF.md
# Bus Traffic Performance Monitor

This block sits next to one bus port and measures how busy it is. A cycle counter counts elapsed clocks. Four event counters count data beats seen on the port. The port reports them as two per-cycle strobes, one for read-data beats and one for write-data beats. Software divides an event count by the cycle count to get port utilization.

Each event counter has its own select register that chooses read beats, write beats or both. The counters are switched on and off individually through a pair of set/clear mask registers. A master run bit in the control register gates every counter at once. Clearing that bit freezes all counts, so software can read a consistent snapshot. Two self-clearing bits in the control register zero the event counters and the cycle counter, and they may be written in the same write that starts the run. Event counter 3 is wider than the others and is read through a low register and a high register.

Registers are reached over a small command/response channel with valid/ready handshakes. A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high whenever no response is pending or the pending response is taken in the same cycle. Every accepted command, read or write, returns exactly one response. A response stays valid with unchanged data until `rsp_ready` is seen high. Read data is sampled at the acceptance edge.

Register word addresses: 0 control (bit 0 run, bit 1 event-counter reset, bit 2 cycle-counter reset), 1 enable-set, 2 enable-clear, 3 cycle count, 4 to 7 select for counters 0 to 3, 8 to 10 counters 0 to 2, 11 counter 3 low part, 12 counter 3 high part.

Top module: `bus_perf_monitor`

## Requirements
- R1: After reset the run bit, the enable mask, all select registers and all counters are zero, `cmd_ready` is 1 and `rsp_valid` is 0.
- R2: Writing the enable-set register (address 1) sets each mask bit written as 1 and leaves bits written as 0 unchanged. The mask has bit n for event counter n and bit 4 for the cycle counter. Reading address 1 or address 2 returns the current mask.
- R3: Writing the enable-clear register (address 2) clears each mask bit written as 1 and leaves bits written as 0 unchanged. A counter whose mask bit is 0 does not advance.
- R4: While the run bit (control bit 0) is 0, no counter advances, whatever the mask. Counts read back unchanged after any amount of beat traffic.
- R5: Select code 1 counts read beats, code 2 counts write beats, code 3 counts both (adding 2 when both strobe in the same cycle), and code 0 counts nothing. Select registers live at addresses 4 to 7, in bits [1:0].
- R6: While running with mask bit 4 set, the cycle counter (address 3) increases by 1 on every clock edge.
- R7: Control bit 1 zeroes all event counters and control bit 2 zeroes the cycle counter at the edge where the write is accepted. Either may be combined with the run bit in one write. Reset wins over an increment in that same cycle, and both bits read back as 0.
- R8: Event counter 3 is WIDE_W bits wide. Address 11 returns its bits [LOW_W-1:0] and address 12 returns its bits [WIDE_W-1:LOW_W]. The full value is (high << LOW_W) | low.
- R9: Counters wrap to zero on overflow: the cycle counter and counters 0 to 2 modulo 2^CNT_W, and counter 3 modulo 2^WIDE_W.
- R10: A command is accepted when `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` is low only while a response is pending with `rsp_ready` low. Each accepted command yields one response in the next cycle, which holds its data until taken. Read data reflects register values at the acceptance edge, and writes respond with 0.
- R11: Addresses 13 to 15 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_write | input | 1 | 1 for write, 0 for read |
| cmd_addr | input | 4 | Register word address |
| cmd_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_data | output | DATA_W | Read data (0 for writes) |
| rd_beat | input | 1 | One read-data beat this cycle |
| wr_beat | input | 1 | One write-data beat this cycle |

## Verification
Two functions can land on the same clock edge: a reset bit in the control register, and an increment from beat strobes while running. The bench provokes this by issuing the control write that sets both reset bits together with the run bit. It does so after a stretch of counting, with both strobes held high on the acceptance edge. It then expects the event counter to read 0 and the cycle counter to show only the edges that followed. A second overlap, a register read accepted while counters advance, is judged by freezing the run bit before every comparison and sweeping select codes, masks and beat patterns. The expected counts come from plain arithmetic in the bench.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int NUM_EVT    = 4;
  localparam int ADDR_W     = 4;
  localparam int SEL_W      = 2;
  localparam int EN_W       = NUM_EVT + 1;
  localparam int EN_CYC_BIT = NUM_EVT;

  localparam int CTRL_RUN     = 0;
  localparam int CTRL_EVT_CLR = 1;
  localparam int CTRL_CYC_CLR = 2;

  localparam int SEL_RD_BIT = 0;
  localparam int SEL_WR_BIT = 1;

  // Select and counter blocks are aligned so that addr[1:0] is the lane index.
  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 4'd0,
    A_EN_SET = 4'd1,
    A_EN_CLR = 4'd2,
    A_CYC    = 4'd3,
    A_SEL0   = 4'd4,
    A_SEL1   = 4'd5,
    A_SEL2   = 4'd6,
    A_SEL3   = 4'd7,
    A_EV0    = 4'd8,
    A_EV1    = 4'd9,
    A_EV2    = 4'd10,
    A_EV3_LO = 4'd11,
    A_EV3_HI = 4'd12
  } pm_reg_e;
endpackage

// File: rtl/pm_counter.sv
module pm_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [1:0]   inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else          count <= count + W'(inc);
  end

  // Per-cycle advance never exceeds two beats (wrap-aware difference).
  assert_step_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (count - $past(count)) <= W'(2));
endmodule

// File: rtl/pm_beat_sel.sv
module pm_beat_sel import pm_pkg::*; (
  input  logic             gate,
  input  logic [SEL_W-1:0] sel,
  input  logic             rd_beat,
  input  logic             wr_beat,
  output logic [1:0]       inc
);
  logic take_rd, take_wr;

  always_comb begin
    take_rd = gate && sel[SEL_RD_BIT] && rd_beat;
    take_wr = gate && sel[SEL_WR_BIT] && wr_beat;
    inc     = 2'(take_rd) + 2'(take_wr);
  end
endmodule

// File: rtl/pm_ctrl.sv
module pm_ctrl import pm_pkg::*; #(
  parameter int DATA_W = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_fire,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DATA_W-1:0]              wdata,
  output logic                           run,
  output logic [EN_W-1:0]                en,
  output logic [NUM_EVT-1:0][SEL_W-1:0]  sel,
  output logic                           evt_clr,
  output logic                           cyc_clr
);
  logic ctrl_hit;
  logic unused_wdata;

  assign unused_wdata = ^wdata;
  assign ctrl_hit     = wr_fire && (addr == A_CTRL);
  assign evt_clr      = ctrl_hit && wdata[CTRL_EVT_CLR];
  assign cyc_clr      = ctrl_hit && wdata[CTRL_CYC_CLR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0;
      en  <= '0;
      sel <= '0;
    end else if (wr_fire) begin
      case (addr)
        A_CTRL:   run <= wdata[CTRL_RUN];
        A_EN_SET: en  <= en | wdata[EN_W-1:0];
        A_EN_CLR: en  <= en & ~wdata[EN_W-1:0];
        default: begin
          for (int i = 0; i < NUM_EVT; i++) begin
            if (addr == ADDR_W'(int'(A_SEL0) + i)) sel[i] <= wdata[SEL_W-1:0];
          end
        end
      endcase
    end
  end

  assert_mask_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && addr == A_EN_SET) |=> ((en & $past(wdata[EN_W-1:0])) == $past(wdata[EN_W-1:0])));

  assert_mask_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && addr == A_EN_CLR) |=> ((en & $past(wdata[EN_W-1:0])) == '0));

  assert_hole_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && addr > A_EV3_HI) |=> ($stable(run) && $stable(en) && $stable(sel)));
endmodule

// File: rtl/pm_port.sv
module pm_port import pm_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int WIDE_W = 40,
  parameter int LOW_W  = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cmd_valid,
  input  logic                           cmd_write,
  input  logic [ADDR_W-1:0]              cmd_addr,
  output logic                           cmd_ready,
  output logic                           wr_fire,
  output logic                           rsp_valid,
  input  logic                           rsp_ready,
  output logic [DATA_W-1:0]              rsp_data,
  input  logic                           run,
  input  logic [EN_W-1:0]                en,
  input  logic [NUM_EVT-1:0][SEL_W-1:0]  sel,
  input  logic [CNT_W-1:0]               cyc,
  input  logic [NUM_EVT-1:0][WIDE_W-1:0] ev_val
);
  localparam int HI_W = WIDE_W - LOW_W;

  logic              fire;
  logic [1:0]        lane;
  logic [DATA_W-1:0] rd_val;
  logic              unused_ev;

  assign unused_ev = ^ev_val;
  assign cmd_ready = !rsp_valid || rsp_ready;
  assign fire      = cmd_valid && cmd_ready;
  assign wr_fire   = fire && cmd_write;
  assign lane      = cmd_addr[1:0];

  always_comb begin
    rd_val = '0;
    case (cmd_addr)
      A_CTRL:                        rd_val[CTRL_RUN]   = run;
      A_EN_SET, A_EN_CLR:            rd_val[EN_W-1:0]   = en;
      A_CYC:                         rd_val[CNT_W-1:0]  = cyc;
      A_SEL0, A_SEL1, A_SEL2, A_SEL3: rd_val[SEL_W-1:0] = sel[lane];
      A_EV0, A_EV1, A_EV2:           rd_val[CNT_W-1:0]  = ev_val[lane][CNT_W-1:0];
      A_EV3_LO:                      rd_val[LOW_W-1:0]  = ev_val[NUM_EVT-1][LOW_W-1:0];
      A_EV3_HI:                      rd_val[HI_W-1:0]   = ev_val[NUM_EVT-1][WIDE_W-1:LOW_W];
      default:                       rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_data  <= cmd_write ? '0 : rd_val;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> rsp_valid);
endmodule

// File: rtl/bus_perf_monitor.sv
module bus_perf_monitor import pm_pkg::*; #(
  parameter int CNT_W  = 32,
  parameter int WIDE_W = 40,
  parameter int LOW_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              rd_beat,
  input  logic              wr_beat
);
  logic                           wr_fire;
  logic                           run;
  logic [EN_W-1:0]                en;
  logic [NUM_EVT-1:0][SEL_W-1:0]  sel;
  logic                           evt_clr, cyc_clr;
  logic [CNT_W-1:0]               cyc;
  logic [1:0]                     cyc_inc;
  logic [NUM_EVT-1:0][WIDE_W-1:0] ev_val;

  pm_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .addr(cmd_addr), .wdata(cmd_wdata),
    .run(run), .en(en), .sel(sel), .evt_clr(evt_clr), .cyc_clr(cyc_clr)
  );

  assign cyc_inc = {1'b0, run && en[EN_CYC_BIT]};

  pm_counter #(.W(CNT_W)) u_cyc (
    .clk(clk), .rst_n(rst_n), .clr(cyc_clr), .inc(cyc_inc), .count(cyc)
  );

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_lane
    logic [1:0] inc;

    pm_beat_sel u_sel (
      .gate(run && en[i]), .sel(sel[i]), .rd_beat(rd_beat), .wr_beat(wr_beat), .inc(inc)
    );

    if (i == NUM_EVT - 1) begin : g_wide
      pm_counter #(.W(WIDE_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(evt_clr), .inc(inc), .count(ev_val[i])
      );
    end else begin : g_narrow
      logic [CNT_W-1:0] cnt;
      pm_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(evt_clr), .inc(inc), .count(cnt)
      );
      assign ev_val[i] = {{(WIDE_W-CNT_W){1'b0}}, cnt};
    end

    assert_evt_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      evt_clr |=> (ev_val[i] == '0));

    assert_evt_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !evt_clr) |=> $stable(ev_val[i]));

    assert_evt_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!en[i] && !evt_clr) |=> $stable(ev_val[i]));
  end

  pm_port #(.DATA_W(DATA_W), .CNT_W(CNT_W), .WIDE_W(WIDE_W), .LOW_W(LOW_W)) u_port (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_ready(cmd_ready), .wr_fire(wr_fire),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .run(run), .en(en), .sel(sel), .cyc(cyc), .ev_val(ev_val)
  );

  assert_cyc_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && en[EN_CYC_BIT] && !cyc_clr) |=> (cyc == $past(cyc) + CNT_W'(1)));

  assert_cyc_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_clr |=> (cyc == '0));

  assert_cyc_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cyc_clr) |=> $stable(cyc));
endmodule

// File: tb/bus_perf_monitor_test.sv
module bus_perf_monitor_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W  = 8;
  localparam int WIDE_W = 12;
  localparam int LOW_W  = 8;
  localparam int DATA_W = 32;

  localparam logic [3:0] R_CTRL = 4'd0, R_ESET = 4'd1, R_ECLR = 4'd2, R_CYC = 4'd3;
  localparam logic [3:0] R_SEL0 = 4'd4, R_EV0 = 4'd8, R_EV3L = 4'd11, R_EV3H = 4'd12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_write = 1'b0, rsp_ready = 1'b1;
  logic rd_beat = 1'b0, wr_beat = 1'b0;
  logic [3:0] cmd_addr = '0;
  logic [DATA_W-1:0] cmd_wdata = '0;
  logic cmd_ready, rsp_valid;
  logic [DATA_W-1:0] rsp_data;

  int checks = 0, errors = 0;
  longint exp_ev [4];
  longint exp_cyc;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_perf_monitor #(.CNT_W(CNT_W), .WIDE_W(WIDE_W), .LOW_W(LOW_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rd_beat(rd_beat), .wr_beat(wr_beat)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic w);
    @(negedge clk);
    cmd_valid = 1'b0; rd_beat = r; wr_beat = w;
    @(posedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic r, input logic w);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = a; cmd_wdata = d;
    rd_beat = r; wr_beat = w;
    @(posedge clk);
  endtask

  task automatic rd(input logic [3:0] a, output longint v);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = a; rd_beat = 1'b0; wr_beat = 1'b0;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    v = rsp_valid ? longint'(rsp_data) : -1;
  endtask

  task automatic read_counts(input string tag);
    longint v, lo, hi;
    rd(R_CYC, v); check({tag, " R6 cycle"}, v, exp_cyc % 256);
    for (int k = 0; k < 3; k++) begin
      rd(R_EV0 + 4'(k), v); check({tag, " R5 event"}, v, exp_ev[k] % 256);
    end
    rd(R_EV3L, lo); rd(R_EV3H, hi);
    check({tag, " R8 event3 low"}, lo, (exp_ev[3] % 4096) % 256);
    check({tag, " R8 event3 high"}, hi, (exp_ev[3] % 4096) / 256);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R10 actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    longint v;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    check("R1 cmd_ready", cmd_ready, 1);
    check("R1 rsp_valid", rsp_valid, 0);
    rd(R_CTRL, v); check("R1 ctrl", v, 0);
    rd(R_ESET, v); check("R1 mask", v, 0);
    rd(R_SEL0, v); check("R1 select", v, 0);
    rd(R_CYC, v);  check("R1 cycle", v, 0);
    rd(R_EV0, v);  check("R1 event0", v, 0);
    rd(R_EV3H, v); check("R1 event3 high", v, 0);

    // R2 R3 R5 R6 sweep of select codes, masks and beat patterns
    for (int p = 0; p < 4; p++) begin
      longint rc, wc;
      int n;
      logic [4:0] m;
      m = 5'h10 | (5'h0F & ~(5'd1 << p));
      for (int k = 0; k < 4; k++) wr(R_SEL0 + 4'(k), 32'((p + k) % 4), 0, 0);
      wr(R_ECLR, 32'h1F, 0, 0);
      wr(R_ESET, 32'(m), 0, 0);
      rd(R_ESET, v); check("R2 mask via set addr", v, m);
      rd(R_ECLR, v); check("R2 mask via clear addr", v, m);
      for (int k = 0; k < 4; k++) begin
        rd(R_SEL0 + 4'(k), v); check("R5 select readback", v, (p + k) % 4);
      end
      wr(R_CTRL, 32'h7, 0, 0);
      rc = 0; wc = 0; n = 20 + p;
      for (int i = 0; i < n; i++) begin
        logic r, w;
        r = ((i + p) % 3) == 0;
        w = (i % 2) == 1;
        rc += r; wc += w;
        step(r, w);
      end
      wr(R_CTRL, 32'h0, 0, 0);
      exp_cyc = n + 1;
      for (int k = 0; k < 4; k++) begin
        int code;
        code = (p + k) % 4;
        exp_ev[k] = (k == p) ? 0 : (((code & 1) != 0 ? rc : 0) + ((code & 2) != 0 ? wc : 0));
      end
      read_counts("sweep R3");
    end

    // R3 partial clear, R2 zero-bit set has no effect
    wr(R_ESET, 32'h0, 0, 0);
    rd(R_ESET, v); check("R2 zero bits ignored", v, 5'h17);
    wr(R_ECLR, 32'h05, 0, 0);
    rd(R_ECLR, v); check("R3 partial clear", v, 5'h12);

    // R4 frozen while run is 0
    for (int i = 0; i < 6; i++) step(1, 1);
    read_counts("freeze R4");

    // R10 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0; cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = R_CYC;
    rd_beat = 1'b0; wr_beat = 1'b0;
    @(posedge clk);
    @(negedge clk);
    cmd_addr = R_EV0 + 4'd1;
    for (int i = 0; i < 3; i++) begin
      check("R10 rsp held", rsp_valid, 1);
      check("R10 ready low", cmd_ready, 0);
      check("R10 data held", rsp_data, exp_cyc % 256);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R10 second rsp", rsp_valid, 1);
    check("R10 second data", rsp_data, exp_ev[1] % 256);

    // R7 reset beats an increment on the same edge
    wr(R_ESET, 32'h1F, 0, 0);
    wr(R_SEL0, 32'h3, 0, 0);
    wr(R_CTRL, 32'h7, 0, 0);
    for (int i = 0; i < 10; i++) step(1, 1);
    wr(R_CTRL, 32'h7, 1, 1);
    rd(R_CTRL, v); check("R7 reset bits read 0", v, 1);
    wr(R_CTRL, 32'h0, 0, 0);
    rd(R_EV0, v); check("R7 event reset wins", v, 0);
    rd(R_CYC, v); check("R7 cycle restarted", v, 3);

    // R11 unmapped addresses
    for (int a = 13; a < 16; a++) begin
      wr(4'(a), 32'hFFFF_FFFF, 0, 0);
      rd(4'(a), v); check("R11 hole reads 0", v, 0);
    end
    rd(R_CTRL, v); check("R11 ctrl untouched", v, 0);
    rd(R_ESET, v); check("R11 mask untouched", v, 5'h1F);

    // R9 R8 wrap of narrow counters and of the wide counter
    for (int k = 0; k < 4; k++) wr(R_SEL0 + 4'(k), 32'h3, 0, 0);
    wr(R_CTRL, 32'h7, 0, 0);
    for (int i = 0; i < 299; i++) step(1, 1);
    wr(R_CTRL, 32'h0, 0, 0);
    exp_cyc = 300;
    for (int k = 0; k < 4; k++) exp_ev[k] = 598;
    read_counts("wrap R9");

    wr(R_CTRL, 32'h7, 0, 0);
    for (int i = 0; i < 2100; i++) step(1, 1);
    wr(R_CTRL, 32'h0, 0, 0);
    exp_cyc = 2101;
    for (int k = 0; k < 4; k++) exp_ev[k] = 4200;
    read_counts("wide wrap R9");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule